// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This unit finishes a floating-point result by rounding its mantissa to the final width. The input carries the kept mantissa bits, plus two extra low bits below them: a guard bit, and a round bit under the guard. A separate sticky bit summarises everything shifted out further down. A sign bit and a 2-bit mode code select one of four rounding behaviours: nearest with ties to even, toward zero, toward plus infinity and toward minus infinity.

The unit drops the two extra bits and adds one at the kept LSB when the mode calls for it. It reports whether that increment happened and whether any precision was lost. An increment on an all-ones mantissa carries into one extra leading bit. That bit is passed out on the wider output so the caller can adjust the exponent and renormalise; this unit does neither. Results are registered, one clock after the inputs are sampled.

Top module: `rnd_unit`

## Requirements
- R1: While `rst_n` is low, `mant_out`, `rounded_up` and `inexact` are all zero.
- R2: When guard (`mant_in[1]`), round (`mant_in[0]`) and `sticky_in` are all zero, the result is exact. `mant_out` equals the kept bits `mant_in[MW+1:2]` zero-extended, and both `rounded_up` and `inexact` are 0, in every mode.
- R3: `inexact` is 1 exactly when at least one of guard, round or sticky is 1, in every mode and for either sign.
- R4: With mode code 2'b00 (nearest), an increment happens only when guard is 1 and at least one of round, sticky or the kept LSB (`mant_in[2]`) is 1. A tie therefore rounds to an even result.
- R5: With mode code 2'b01 (toward zero), no increment ever happens.
- R6: With mode code 2'b10 (toward plus infinity), an increment happens exactly when the result is inexact and `sign_in` is 0.
- R7: With mode code 2'b11 (toward minus infinity), an increment happens exactly when the result is inexact and `sign_in` is 1.
- R8: `mant_out` (MW+1 bits) equals the kept bits plus the increment, with the carry propagated across the full width. An all-ones kept field that is incremented gives `mant_out` with only bit MW set.
- R9: `rounded_up` is 1 exactly when an increment was applied, and an increment implies `inexact`.
- R10: Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mant_in | input | MW+2 | Kept mantissa in bits MW+1..2, guard in bit 1, round in bit 0 |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 for negative |
| mode_in | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_out | output | MW+1 | Rounded mantissa, bit MW is the carry-out |
| rounded_up | output | 1 | An increment was applied |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The bench builds the unit with MW = 8 rather than the default 24. At that width every kept value can be crossed with every guard, round, sticky, sign and mode combination, 16384 vectors in all. This puts the all-ones carry-out into the top bit and every tie case under both LSB parities within the sweep. A narrow width also makes a broken carry chain show up at each bit position, not just at the low end.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TO_ZERO = 2'b01,
    RM_TO_POS  = 2'b10,
    RM_TO_NEG  = 2'b11
  } rnd_mode_e;

  // Any discarded information below the kept LSB.
  function automatic logic lost_bits(input logic g, input logic r, input logic s);
    return g | r | s;
  endfunction

  // Nearest-even: above half always rounds up; exactly half rounds to even.
  function automatic logic nearest_up(input logic lsb, input logic g,
                                      input logic r, input logic s);
    return g & (r | s | lsb);
  endfunction

  // Directed modes: move away from zero only when heading toward the
  // infinity that matches the sign.
  function automatic logic directed_up(input rnd_mode_e m, input logic neg,
                                       input logic lost);
    logic up;
    case (m)
      RM_TO_POS: up = lost & ~neg;
      RM_TO_NEG: up = lost & neg;
      default:   up = 1'b0;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      lsb,
  input  logic      guard_b,
  input  logic      round_b,
  input  logic      sticky_b,
  input  logic      neg,
  input  rnd_mode_e mode,
  output logic      inc,
  output logic      lost
);

  logic near_inc;
  logic dir_inc;

  assign lost     = lost_bits(guard_b, round_b, sticky_b);
  assign near_inc = nearest_up(lsb, guard_b, round_b, sticky_b);
  assign dir_inc  = directed_up(mode, neg, lost);

  always_comb begin
    if (mode == RM_NEAREST) inc = near_inc;
    else                    inc = dir_inc;
  end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int MW = 24
) (
  input  logic [MW-1:0] kept,
  input  logic          inc,
  output logic [MW:0]   sum
);

  logic [MW:0] carry;

  assign carry[0] = inc;

  for (genvar i = 0; i < MW; i++) begin : g_bit
    assign sum[i]     = kept[i] ^ carry[i];
    assign carry[i+1] = kept[i] & carry[i];
  end

  assign sum[MW] = carry[MW];

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int MW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW+1:0] mant_in,
  input  logic          sticky_in,
  input  logic          sign_in,
  input  logic [1:0]    mode_in,
  output logic [MW:0]   mant_out,
  output logic          rounded_up,
  output logic          inexact
);

  localparam int KW = MW;

  logic [KW-1:0] kept_w;
  logic          guard_w;
  logic          round_w;
  logic          inc_w;
  logic          lost_w;
  logic [KW:0]   sum_w;
  rnd_mode_e     mode_w;

  assign kept_w  = mant_in[KW+1:2];
  assign guard_w = mant_in[1];
  assign round_w = mant_in[0];
  assign mode_w  = rnd_mode_e'(mode_in);

  rnd_decide u_decide (
    .lsb      (kept_w[0]),
    .guard_b  (guard_w),
    .round_b  (round_w),
    .sticky_b (sticky_in),
    .neg      (sign_in),
    .mode     (mode_w),
    .inc      (inc_w),
    .lost     (lost_w)
  );

  rnd_incr #(.MW(KW)) u_incr (
    .kept (kept_w),
    .inc  (inc_w),
    .sum  (sum_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_out   <= '0;
      rounded_up <= 1'b0;
      inexact    <= 1'b0;
    end else begin
      mant_out   <= sum_w;
      rounded_up <= inc_w;
      inexact    <= lost_w;
    end
  end

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int MW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW+1:0] mant_in,
  input logic          sticky_in,
  input logic          sign_in,
  input logic [1:0]    mode_in,
  input logic [MW:0]   mant_out,
  input logic          rounded_up,
  input logic          inexact
);

  logic tail_nz;
  assign tail_nz = mant_in[1] | mant_in[0] | sticky_in;

  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_nz |=> (!rounded_up && !inexact)); // R2

  AST_INEXACT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (inexact == $past(tail_nz))); // R3

  AST_NEAR_NEEDS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00 && !mant_in[1]) |=> !rounded_up); // R4

  AST_RTZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b01) |=> !rounded_up); // R5

  AST_POS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b10) |=> (rounded_up == $past(tail_nz && !sign_in))); // R6

  AST_NEG_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b11) |=> (rounded_up == $past(tail_nz && sign_in))); // R7

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mant_out == ({1'b0, $past(mant_in[MW+1:2])} + {{MW{1'b0}}, rounded_up}))); // R8

  AST_UP_IS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    rounded_up |-> inexact); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (mant_out == '0 && !rounded_up && !inexact); // R1
    end
  end

endmodule

bind rnd_unit rnd_unit_chk #(.MW(MW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mant_in    (mant_in),
  .sticky_in  (sticky_in),
  .sign_in    (sign_in),
  .mode_in    (mode_in),
  .mant_out   (mant_out),
  .rounded_up (rounded_up),
  .inexact    (inexact)
);

// File: tb/tb_rnd_unit.sv
module tb_rnd_unit;

  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [MW+1:0] mant_in = '0;
  logic          sticky_in = 1'b0;
  logic          sign_in = 1'b0;
  logic [1:0]    mode_in = 2'b00;
  logic [MW:0]   mant_out;
  logic          rounded_up;
  logic          inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [MW:0] e_mant;
    logic        e_up;
    logic        e_inx;
    logic [1:0]  mode;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  rnd_unit #(.MW(MW)) dut (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
    .sign_in(sign_in), .mode_in(mode_in), .mant_out(mant_out),
    .rounded_up(rounded_up), .inexact(inexact)
  );

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference model: compare the discarded tail against one half ulp.
  task automatic apply(input logic [MW-1:0] k, input logic g, input logic r,
                       input logic s, input logic neg, input logic [1:0] m);
    exp_t e;
    logic [1:0] tail;
    logic       up;
    logic       any;
    @(negedge clk);
    mant_in   = {k, g, r};
    sticky_in = s;
    sign_in   = neg;
    mode_in   = m;
    tail = {g, r | s};
    any  = (tail != 2'b00);
    case (m)
      2'b00:   up = (tail == 2'b11) || (tail == 2'b10 && k[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = any && !neg;
      default: up = any && neg;
    endcase
    e.e_mant = {1'b0, k} + (MW+1)'(up);
    e.e_up   = up;
    e.e_inx  = any;
    e.mode   = m;
    sb.push_back(e);
  endtask

  // Monitor: R10 one-cycle latency, result compared just after the edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (mant_out !== e.e_mant) begin
        fails++;
        $display("FAIL R8 mant_out got %h expected %h", mant_out, e.e_mant);
      end else if (rounded_up !== e.e_up) begin
        fails++;
        $display("FAIL %s/R9 rounded_up got %b expected %b", mode_req(e.mode),
                 rounded_up, e.e_up);
      end else if (inexact !== e.e_inx) begin
        fails++;
        $display("FAIL %s inexact got %b expected %b", e.e_inx ? "R3" : "R2",
                 inexact, e.e_inx);
      end
    end
  end

  initial begin
    // R1: reset holds outputs clear even with live inputs.
    mant_in = '1; sticky_in = 1'b1; sign_in = 1'b1; mode_in = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mant_out !== '0 || rounded_up !== 1'b0 || inexact !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs got %h/%b/%b expected 0/0/0",
               mant_out, rounded_up, inexact);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // Directed corners: R2 exact, R4 ties both parities, R8 carry-out.
    apply(8'h55, 0, 0, 0, 0, 2'b00);
    apply(8'h54, 1, 0, 0, 0, 2'b00);
    apply(8'h55, 1, 0, 0, 0, 2'b00);
    apply(8'hFF, 1, 1, 0, 0, 2'b00);
    apply(8'hFF, 0, 0, 1, 0, 2'b10);
    apply(8'hFF, 0, 0, 1, 1, 2'b11);
    apply(8'hFF, 1, 1, 1, 1, 2'b01);
    // Exhaustive sweep, all modes (R3 R5 R6 R7 R9).
    for (int k = 0; k < (1 << MW); k++)
      for (int t = 0; t < 8; t++)
        for (int sg = 0; sg < 2; sg++)
          for (int m = 0; m < 4; m++)
            apply(MW'(k), t[2], t[1], t[0], sg[0], 2'(m));
    @(negedge clk);
    mant_in = '0; sticky_in = 1'b0;
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired with %0d items pending", sb.size());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule